// File: doc/BRIEF.md
# JTAG Shift Sequencer

This block is a JTAG master engine for a debug-probe controller. Software places scan commands in a command queue. The engine works through them in order and drives TCK, TMS and TDI toward a target's test access port, sampling TDO as it goes. It keeps its own copy of the target's TAP controller state. A shift command names the state to shift in (IR-shift, DR-shift or Run-Test/Idle), the state to finish in, a bit count and a 32-bit payload. For each shift command the engine walks from the tracked state to the shift state, clocks the payload, and then walks on to the finishing state.

Two more commands complete the set. One produces a single TCK pulse with a chosen TMS level. The other overwrites the tracked state without any clocking, for use after a hardware reset of the target.

TCK is derived from the system clock by an even divisor. In return-clock mode, each TCK edge instead waits for the target to echo the previous edge. A missing echo sets a sticky error flag after a bounded wait.

Top module: `jtag_shift_seq`

## Requirements
- R1: TAP states use the 4-bit codes Exit2-DR 0, Exit1-DR 1, Shift-DR 2, Pause-DR 3, Select-IR 4, Update-DR 5, Capture-DR 6, Select-DR 7, Exit2-IR 8, Exit1-IR 9, Shift-IR A, Pause-IR B, Idle C, Update-IR D, Capture-IR E, Test-Logic-Reset F. After reset:
  - the tracked state reads F;
  - TCK is low;
  - busy, the error flag and the capture word are all 0.
- R2: A command is queued by a push strobe and carries five fields:
  - op: 0 = shift, 1 = single step, 2 = set state;
  - shift state;
  - end state;
  - length field equal to the bit count minus one (1 to 32 bits);
  - 32-bit value.

  A shift command drives the value onto TDI least significant bit first.
- R3: Before shifting, the engine walks the tracked state to the requested shift state with legal TMS values. Every bit clocked while the target is in Shift-IR or Shift-DR belongs to the payload. Afterwards the tracked state matches the target's actual state.
- R4: When the end state differs from the shift state, TMS is 1 on the last payload bit. The engine then walks from Exit1 to the end state, for example one further clock with TMS 0 to reach Pause.
- R5: When the end state equals the shift state, the TAP stays in that shift state after the last bit. A following command in the same shift state continues the scan with no extra clocks.
- R6: Each TDO bit sampled at a TCK rising edge of a shift command enters the capture word at bit 31 and shifts it right. The word is cleared at the start of every shift command. After k bits the captured data sits in the top k bits.
- R7: A shift command in Idle with end state Idle produces exactly as many TCK cycles in Idle as its bit count.
- R8: The TCK period equals the divisor in system clocks. An odd divisor is rounded down to even, and a divisor below 2 acts as 2.
- R9: A single-step command produces exactly one TCK pulse, with TMS equal to value bit 0, and advances the tracked state by that TMS.
- R10: A set-state command loads the end-state field into the tracked state without producing any TCK pulse.
- R11: In return-clock mode, each TCK edge waits for the synchronised returned clock to match TCK. If it has not matched after a fixed number of cycles, the engine proceeds and sets a sticky error flag. The flag stays set until the clear strobe and can never be set in divider mode.
- R12: Commands are executed in push order from a queue of at least 16 entries. Busy stays high while any command is queued or in progress, and TCK is low whenever busy is low.
- R13: TMS and TDI change only while TCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_push | input | 1 | Queue the command on the cmd_* inputs |
| cmd_op | input | 2 | Command kind: 0 shift, 1 step, 2 set state |
| cmd_shift | input | 4 | State in which the payload is shifted |
| cmd_end | input | 4 | Finishing state, or new state for set |
| cmd_len_m1 | input | 5 | Bit count minus one |
| cmd_value | input | 32 | Payload, LSB first; bit 0 is the step TMS |
| fifo_full | output | 1 | Queue cannot accept a push |
| cfg_div | input | 13 | TCK divisor in system clocks |
| cfg_rclk | input | 1 | 1 selects return-clock pacing |
| rclk_in | input | 1 | Returned clock from the target |
| rclk_err_clr | input | 1 | Clears the timeout flag |
| rclk_err | output | 1 | Sticky return-clock timeout flag |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward the target |
| tdo | input | 1 | Test data from the target |
| cap_data | output | 32 | Left-aligned captured TDO bits |
| tap_state | output | 4 | Tracked TAP state code |
| busy | output | 1 | Queue not empty or command running |

## Verification
Two situations are the hardest to reach from the ports.

The first is the return-clock timeout. The bench reaches it by detaching the returned clock from its delayed TCK echo and tying it low, so the high phase of the next TCK can only end through the wait limit.

The second is scan chaining. A transfer must stay in Shift-DR across a command boundary, and the continuation must be checked as well. The bench watches the pins with its own TAP model, so any stray clock between the two commands is seen as a bit that no payload accounts for.

// File: rtl/jss_pkg.sv
// jss_pkg: shared types and TAP navigation helpers for the JTAG shift sequencer.
// Assumes the 16-state TAP controller with the 4-bit state codes listed below.
package jss_pkg;
    localparam int VAL_W = 32;
    localparam int LEN_W = $clog2(VAL_W);

    typedef enum logic [3:0] {
        TAP_EX2_DR = 4'h0, TAP_EX1_DR = 4'h1, TAP_SH_DR  = 4'h2, TAP_PA_DR  = 4'h3,
        TAP_SEL_IR = 4'h4, TAP_UPD_DR = 4'h5, TAP_CAP_DR = 4'h6, TAP_SEL_DR = 4'h7,
        TAP_EX2_IR = 4'h8, TAP_EX1_IR = 4'h9, TAP_SH_IR  = 4'hA, TAP_PA_IR  = 4'hB,
        TAP_IDLE   = 4'hC, TAP_UPD_IR = 4'hD, TAP_CAP_IR = 4'hE, TAP_RESET  = 4'hF
    } tap_e;

    typedef enum logic [1:0] {OP_SHIFT = 2'd0, OP_STEP = 2'd1, OP_SET = 2'd2} op_e;

    typedef struct packed {
        op_e              op;
        tap_e             shift_st;
        tap_e             end_st;
        logic [LEN_W-1:0] len_m1;
        logic [VAL_W-1:0] value;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    // Successor of a TAP state for one TCK with the given TMS.
    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            TAP_RESET:  return m ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   return m ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: return m ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: return m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  return m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: return m ? TAP_UPD_DR : TAP_PA_DR;
            TAP_PA_DR:  return m ? TAP_EX2_DR : TAP_PA_DR;
            TAP_EX2_DR: return m ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: return m ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: return m ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: return m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  return m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: return m ? TAP_UPD_IR : TAP_PA_IR;
            TAP_PA_IR:  return m ? TAP_EX2_IR : TAP_PA_IR;
            TAP_EX2_IR: return m ? TAP_UPD_IR : TAP_SH_IR;
            default:    return m ? TAP_SEL_DR : TAP_IDLE;
        endcase
    endfunction

    // True for states in the data-register column.
    function automatic logic in_dr_col(tap_e s);
        return s inside {TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR,
                         TAP_PA_DR, TAP_EX2_DR, TAP_UPD_DR};
    endfunction

    // True for states in the instruction-register column.
    function automatic logic in_ir_col(tap_e s);
        return s inside {TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR,
                         TAP_PA_IR, TAP_EX2_IR, TAP_UPD_IR};
    endfunction

    // TMS value that moves one step along a shortest path from cur toward tgt.
    function automatic logic tms_toward(tap_e cur, tap_e tgt);
        if (tgt == TAP_RESET) return 1'b1;
        case (cur)
            TAP_RESET:  return 1'b0;
            TAP_IDLE:   return 1'b1;
            TAP_SEL_DR: return !in_dr_col(tgt);
            TAP_SEL_IR: return !in_ir_col(tgt);
            TAP_CAP_DR: return tgt != TAP_SH_DR;
            TAP_EX1_DR: return tgt != TAP_PA_DR;
            TAP_EX2_DR: return tgt != TAP_SH_DR;
            TAP_UPD_DR: return tgt != TAP_IDLE;
            TAP_CAP_IR: return tgt != TAP_SH_IR;
            TAP_EX1_IR: return tgt != TAP_PA_IR;
            TAP_EX2_IR: return tgt != TAP_SH_IR;
            TAP_UPD_IR: return tgt != TAP_IDLE;
            default:    return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/jss_cmd_fifo.sv
// jss_cmd_fifo: first-in first-out command store.
// Assumes the caller never pops when empty; a push while full is dropped.
module jss_cmd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= din;
    end

    // Pointer update for push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/jss_tck_pacer.sv
// jss_tck_pacer: turns a bit request into one TCK cycle. Each half period is
// timed by the divider, or by the synchronised returned clock with a bounded
// wait. Assumes bit_vld stays stable until done, and changes only with done.
module jss_tck_pacer #(
    parameter int DIV_W = 13,
    parameter int TMO   = 64,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic [DIV_W-1:0] div,
    input  logic             rclk_mode,
    input  logic             rclk_in,
    input  logic             err_clr,
    output logic             tck,
    output logic             rise,
    output logic             done,
    output logic             err
);
    localparam int TW = $clog2(TMO + 1);

    logic [DIV_W-1:0] half, half_m1, cnt;
    logic [TW-1:0]    tcnt;
    logic [SYNC-1:0]  rsync;
    logic             active, ready, rclk_ok, tmo_hit;

    // Half period in system clocks, never below one.
    always_comb begin
        half    = div >> 1;
        if (half == '0) half = {{(DIV_W-1){1'b0}}, 1'b1};
        half_m1 = half - {{(DIV_W-1){1'b0}}, 1'b1};
    end

    assign rclk_ok = (rsync[SYNC-1] == tck);
    assign tmo_hit = (tcnt == TW'(TMO - 1));
    assign ready   = rclk_mode ? (rclk_ok || tmo_hit) : (cnt == half_m1);
    assign active  = tck || bit_vld;
    assign rise    = !tck && bit_vld && ready;
    assign done    = tck && ready;

    // Returned-clock synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) rsync <= '0;
        else        rsync <= {rsync[SYNC-2:0], rclk_in};
    end

    // Phase timing and TCK toggling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck  <= 1'b0;
            cnt  <= '0;
            tcnt <= '0;
        end else if (!active) begin
            cnt  <= '0;
            tcnt <= '0;
        end else if (ready) begin
            tck  <= !tck;
            cnt  <= '0;
            tcnt <= '0;
        end else begin
            cnt  <= cnt + 1'b1;
            tcnt <= tcnt + 1'b1;
        end
    end

    // Sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                                           err <= 1'b0;
        else if (err_clr)                                     err <= 1'b0;
        else if (rclk_mode && active && tmo_hit && !rclk_ok)  err <= 1'b1;
    end
endmodule

// File: rtl/jss_engine.sv
// jss_engine: pops commands, tracks the TAP state and requests one TCK cycle
// at a time from the pacer. State changes happen on the pacer's done pulse
// (TCK falling), so TMS and TDI stay constant for a whole TCK cycle.
module jss_engine
    import jss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             empty,
    input  cmd_t             head,
    output logic             pop,
    output logic             bit_vld,
    output logic             bit_tms,
    output logic             bit_tdi,
    input  logic             rise,
    input  logic             done,
    input  logic             tdo,
    output tap_e             tap,
    output logic [VAL_W-1:0] cap,
    output logic             busy
);
    typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_SHIFT, PH_POST, PH_STEP} ph_e;

    ph_e              ph;
    cmd_t             cmd;
    logic [LEN_W-1:0] idx;
    logic             last;

    assign last = (idx == cmd.len_m1);
    assign pop  = (ph == PH_IDLE) && !empty;
    assign busy = (ph != PH_IDLE) || !empty;

    // Pin values requested for the current TCK cycle.
    always_comb begin
        bit_vld = 1'b0;
        bit_tms = 1'b0;
        bit_tdi = 1'b0;
        case (ph)
            PH_PRE: begin
                bit_vld = (tap != cmd.shift_st);
                bit_tms = tms_toward(tap, cmd.shift_st);
            end
            PH_SHIFT: begin
                bit_vld = 1'b1;
                bit_tdi = cmd.value[idx];
                bit_tms = last && (cmd.end_st != cmd.shift_st);
            end
            PH_POST: begin
                bit_vld = (tap != cmd.end_st);
                bit_tms = tms_toward(tap, cmd.end_st);
            end
            PH_STEP: begin
                bit_vld = 1'b1;
                bit_tms = cmd.value[0];
            end
            default: ;
        endcase
    end

    // Command sequencing, TAP tracking and TDO capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cmd <= '0;
            idx <= '0;
            tap <= TAP_RESET;
            cap <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (!empty) begin
                    cmd <= head;
                    idx <= '0;
                    case (head.op)
                        OP_SHIFT: begin ph <= PH_PRE; cap <= '0; end
                        OP_STEP:  ph <= PH_STEP;
                        default:  tap <= head.end_st;
                    endcase
                end
                PH_PRE: begin
                    if (tap == cmd.shift_st) ph  <= PH_SHIFT;
                    else if (done)           tap <= tap_next(tap, bit_tms);
                end
                PH_SHIFT: begin
                    if (rise) cap <= {tdo, cap[VAL_W-1:1]};
                    if (done) begin
                        tap <= tap_next(tap, bit_tms);
                        if (last) ph  <= PH_POST;
                        else      idx <= idx + 1'b1;
                    end
                end
                PH_POST: begin
                    if (tap == cmd.end_st) ph  <= PH_IDLE;
                    else if (done)         tap <= tap_next(tap, bit_tms);
                end
                PH_STEP: if (done) begin
                    tap <= tap_next(tap, bit_tms);
                    ph  <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/jtag_shift_seq.sv
// jtag_shift_seq: JTAG master top. A command queue feeds the sequencing
// engine, and a pacer times each TCK cycle. Assumes software only requests
// stable end states and shift states of Shift-IR, Shift-DR or Idle.
module jtag_shift_seq
    import jss_pkg::*;
#(
    parameter int DIV_W      = 13,
    parameter int FIFO_DEPTH = 16,
    parameter int RCLK_TMO   = 64,
    parameter int RCLK_SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_push,
    input  logic [1:0]       cmd_op,
    input  logic [3:0]       cmd_shift,
    input  logic [3:0]       cmd_end,
    input  logic [LEN_W-1:0] cmd_len_m1,
    input  logic [VAL_W-1:0] cmd_value,
    output logic             fifo_full,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_rclk,
    input  logic             rclk_in,
    input  logic             rclk_err_clr,
    output logic             rclk_err,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    input  logic             tdo,
    output logic [VAL_W-1:0] cap_data,
    output logic [3:0]       tap_state,
    output logic             busy
);
    logic [CMD_W-1:0] push_word, head_word;
    logic             empty, pop, bit_vld, rise, done;
    tap_e             tap;

    assign push_word = {cmd_op, cmd_shift, cmd_end, cmd_len_m1, cmd_value};
    assign tap_state = tap;

    jss_cmd_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(push_word),
        .full(fifo_full), .pop(pop), .dout(head_word), .empty(empty)
    );

    jss_engine u_eng (
        .clk(clk), .rst_n(rst_n), .empty(empty), .head(cmd_t'(head_word)),
        .pop(pop), .bit_vld(bit_vld), .bit_tms(tms), .bit_tdi(tdi),
        .rise(rise), .done(done), .tdo(tdo), .tap(tap), .cap(cap_data),
        .busy(busy)
    );

    jss_tck_pacer #(.DIV_W(DIV_W), .TMO(RCLK_TMO), .SYNC(RCLK_SYNC)) u_pacer (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .div(cfg_div),
        .rclk_mode(cfg_rclk), .rclk_in(rclk_in), .err_clr(rclk_err_clr),
        .tck(tck), .rise(rise), .done(done), .err(rclk_err)
    );
endmodule

// File: rtl/jss_checker.sv
// jss_checker: temporal properties of the JTAG shift sequencer's ports,
// attached to every instance of the top through bind.
module jss_checker (
    input logic clk,
    input logic rst_n,
    input logic tck,
    input logic tms,
    input logic tdi,
    input logic busy,
    input logic rclk_err,
    input logic rclk_err_clr,
    input logic cfg_rclk
);
    // Pins hold still through each TCK high phase.
    AST_PINS_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi))); // R13

    // The timeout flag is sticky until cleared.
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rclk_err && !rclk_err_clr) |=> rclk_err); // R11

    // The timeout flag rises only in return-clock mode.
    AST_ERR_ONLY_RCLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rclk_err) |-> $past(cfg_rclk)); // R11

    // No clock is left high once the engine is idle.
    AST_IDLE_TCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck); // R12

    // A TCK rising edge only comes from work in progress.
    AST_RISE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> $past(busy)); // R12
endmodule

bind jtag_shift_seq jss_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .busy(busy),
    .rclk_err(rclk_err), .rclk_err_clr(rclk_err_clr), .cfg_rclk(cfg_rclk)
);

// File: tb/jtag_shift_seq_test.sv
// Scoreboard bench: drivers queue the expected TMS/TDI of each payload bit;
// a pin monitor with its own TAP model pops and compares at each TCK rise.
module jtag_shift_seq_test;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] TDO_WORD   = 32'hC3A5_1E69;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_push = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  cmd_shift = '0, cmd_end = '0;
    logic [4:0]  cmd_len_m1 = '0;
    logic [31:0] cmd_value = '0;
    logic [12:0] cfg_div = 13'd4;
    logic        cfg_rclk = 1'b0, rclk_stuck = 1'b0, rclk_err_clr = 1'b0;
    logic [1:0]  echo = '0;
    logic        rclk_in, fifo_full, rclk_err, tck, tms, tdi, tdo, busy;
    logic [31:0] cap_data;
    logic [3:0]  tap_state;

    int   n_cmp = 0, n_bad = 0, bitcnt = 0, rises = 0, idle_rises = 0;
    logic [3:0] mdl = 4'hF;
    logic [1:0] sb_q [$];
    time  t_prev = 0, t_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) echo <= {echo[0], tck};
    assign rclk_in = rclk_stuck ? 1'b0 : echo[1];
    assign tdo     = TDO_WORD[bitcnt[4:0]];

    jtag_shift_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_op(cmd_op),
        .cmd_shift(cmd_shift), .cmd_end(cmd_end), .cmd_len_m1(cmd_len_m1),
        .cmd_value(cmd_value), .fifo_full(fifo_full), .cfg_div(cfg_div),
        .cfg_rclk(cfg_rclk), .rclk_in(rclk_in), .rclk_err_clr(rclk_err_clr),
        .rclk_err(rclk_err), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .cap_data(cap_data), .tap_state(tap_state), .busy(busy)
    );

    function automatic logic [3:0] b_next(input logic [3:0] s, input logic m);
        case (s)
            4'hF: return m ? 4'hF : 4'hC;  4'hC: return m ? 4'h7 : 4'hC;
            4'h7: return m ? 4'h4 : 4'h6;  4'h6: return m ? 4'h1 : 4'h2;
            4'h2: return m ? 4'h1 : 4'h2;  4'h1: return m ? 4'h5 : 4'h3;
            4'h3: return m ? 4'h0 : 4'h3;  4'h0: return m ? 4'h5 : 4'h2;
            4'h5: return m ? 4'h7 : 4'hC;  4'h4: return m ? 4'hF : 4'hE;
            4'hE: return m ? 4'h9 : 4'hA;  4'hA: return m ? 4'h9 : 4'hA;
            4'h9: return m ? 4'hD : 4'hB;  4'hB: return m ? 4'h8 : 4'hB;
            4'h8: return m ? 4'hD : 4'hA;  default: return m ? 4'h7 : 4'hC;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compares payload bits and follows the target's TAP.
    initial begin
        forever begin
            @(posedge tck);
            #1;
            if (mdl == 4'h2 || mdl == 4'hA) begin
                if (sb_q.size() == 0) check("R3 unexpected shift bit", 32'd1, 32'd0);
                else check("R2/R4 shift bit tms,tdi", {30'd0, tms, tdi}, {30'd0, sb_q.pop_front()});
                bitcnt++;
            end
            if (mdl == 4'hC) idle_rises++;
            rises++;
            t_prev = t_last;
            t_last = $time;
            mdl = b_next(mdl, tms);
        end
    end

    task automatic push_cmd(input logic [1:0] op, input logic [3:0] sh, input logic [3:0] en,
                            input logic [4:0] lm1, input logic [31:0] val);
        @(negedge clk);
        cmd_op = op; cmd_shift = sh; cmd_end = en; cmd_len_m1 = lm1; cmd_value = val;
        cmd_push = 1'b1;
        @(negedge clk);
        cmd_push = 1'b0;
    endtask

    // Driver: queues expected payload bits, then the shift command.
    task automatic do_shift(input logic [3:0] sh, input logic [3:0] en, input int n,
                            input logic [31:0] val);
        if (sh == 4'h2 || sh == 4'hA)
            for (int i = 0; i < n; i++) sb_q.push_back({(i == n - 1) && (en != sh), val[i]});
        push_cmd(2'd0, sh, en, 5'(n - 1), val);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic prep();
        bitcnt = 0; rises = 0; idle_rises = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 tap after reset", {28'd0, tap_state}, 32'hF);
        check("R1 tck/busy/err after reset", {29'd0, tck, busy, rclk_err}, 32'd0);
        check("R1 capture after reset", cap_data, 32'd0);

        // R3 R4 R6: IR shift from reset, ending in Idle
        prep();
        do_shift(4'hA, 4'hC, 6, 32'h2A);
        wait_idle();
        check("R3 tap after IR scan", {28'd0, tap_state}, 32'hC);
        check("R3 target model after IR scan", {28'd0, mdl}, 32'hC);
        check("R6 IR capture left aligned", cap_data, TDO_WORD << 26);
        check("R3 all IR bits consumed", sb_q.size(), 0);

        // R5 R8: 32-bit DR shift staying in Shift-DR
        prep();
        do_shift(4'h2, 4'h2, 32, 32'hDEAD_BEEF);
        wait_idle();
        check("R5 stays in Shift-DR", {28'd0, tap_state}, 32'h2);
        check("R6 full capture", cap_data, TDO_WORD);
        check("R8 period div 4", 32'(t_last - t_prev), 32'(4 * CLK_PERIOD));
        check("R12 idle pins", {30'd0, tck, busy}, 32'd0);

        // R5 R4: chained continuation, then exit to Pause-DR
        prep();
        do_shift(4'h2, 4'h3, 8, 32'hA5);
        wait_idle();
        check("R5 chained rises (8 bits + Exit1->Pause)", rises, 9);
        check("R4 tap in Pause-DR", {28'd0, tap_state}, 32'h3);
        check("R6 8-bit capture", cap_data, TDO_WORD << 24);
        check("R5 all DR bits consumed", sb_q.size(), 0);

        // R7: free-running clocks in Idle
        prep();
        do_shift(4'hC, 4'hC, 10, 32'd0);
        wait_idle();
        check("R7 clocks spent in Idle", idle_rises, 10);
        check("R7 tap in Idle", {28'd0, tap_state}, 32'hC);

        // R9: single step with TMS 1
        prep();
        push_cmd(2'd1, 4'h0, 4'h0, 5'd0, 32'h1);
        wait_idle();
        check("R9 one TCK for step", rises, 1);
        check("R9 tap after step", {28'd0, tap_state}, 32'h7);

        // R10: set state with no clocks
        prep();
        push_cmd(2'd2, 4'h0, 4'hF, 5'd0, 32'd0);
        wait_idle();
        repeat (10) @(negedge clk);
        check("R10 no TCK for set", rises, 0);
        check("R10 tap overwritten", {28'd0, tap_state}, 32'hF);
        mdl = 4'hF;

        // R8: divisor 10
        cfg_div = 13'd10;
        prep();
        do_shift(4'h2, 4'h2, 16, 32'h1234);
        wait_idle();
        check("R8 period div 10", 32'(t_last - t_prev), 32'(10 * CLK_PERIOD));

        // R8: odd divisor rounds down
        cfg_div = 13'd7;
        prep();
        do_shift(4'h2, 4'h2, 4, 32'h9);
        wait_idle();
        check("R8 period odd div 7", 32'(t_last - t_prev), 32'(6 * CLK_PERIOD));

        // R8: divisor below 2 acts as 2
        cfg_div = 13'd1;
        prep();
        do_shift(4'h2, 4'h3, 4, 32'h6);
        wait_idle();
        check("R8 period div 1", 32'(t_last - t_prev), 32'(2 * CLK_PERIOD));
        check("R11 no error in divider mode", {31'd0, rclk_err}, 32'd0);

        // R11: return-clock mode with a live echo
        cfg_div = 13'd4;
        cfg_rclk = 1'b1;
        prep();
        do_shift(4'hA, 4'hC, 5, 32'h13);
        wait_idle();
        check("R11 rclk scan ends in Idle", {28'd0, tap_state}, 32'hC);
        check("R11 no timeout with echo", {31'd0, rclk_err}, 32'd0);
        check("R11 rclk capture", cap_data, TDO_WORD << 27);

        // R11: stuck returned clock times out, flag is sticky, then cleared
        rclk_stuck = 1'b1;
        prep();
        push_cmd(2'd1, 4'h0, 4'h0, 5'd0, 32'h0);
        wait_idle();
        repeat (20) @(negedge clk);
        check("R11 timeout flag sticky", {31'd0, rclk_err}, 32'd1);
        check("R11 step still completes", rises, 1);
        rclk_err_clr = 1'b1;
        @(negedge clk);
        rclk_err_clr = 1'b0;
        @(negedge clk);
        check("R11 flag cleared", {31'd0, rclk_err}, 32'd0);
        rclk_stuck = 1'b0;
        cfg_rclk = 1'b0;

        // R12: back-to-back commands run in push order
        prep();
        push_cmd(2'd1, 4'h0, 4'h0, 5'd0, 32'h1);
        push_cmd(2'd1, 4'h0, 4'h0, 5'd0, 32'h0);
        push_cmd(2'd1, 4'h0, 4'h0, 5'd0, 32'h0);
        check("R12 busy while queued", {31'd0, busy}, 32'd1);
        wait_idle();
        check("R12 queued steps clock count", rises, 3);
        check("R12 queued steps order", {28'd0, tap_state}, 32'h2);
        check("R12 queue not full", {31'd0, fifo_full}, 32'd0);

        finish_run();
    end
endmodule